// File: doc/BRIEF.md
# Macro-op Expander and Group Packer

This block sits between an instruction classifier and an in-order control unit. Every instruction that arrives on its valid/ready input carries a small opcode tag and a two-bit path code. A single-rate instruction becomes one macro-op. A double-rate instruction becomes two adjacent macro-ops. A sequenced instruction starts a walk through an on-chip microcode table. The table is indexed by the tag through a start-address lookup. Each table word holds one macro-op and a terminal flag. The walk reads up to three consecutive words per cycle and stops at the first flagged word.

The expanded stream goes into a small circular pack queue. The queue releases macro-ops only as dense groups of three. A partial group leaves only while the flush input is high, and its unused upper slots are marked empty. The output is a valid/ready group port with three macro-op slots and one valid bit per slot.

Each macro-op is `{kind[1:0], tag[3:0], step[1:0]}`, with the step in the least significant bits. Slot 0 occupies the lowest eight bits of `out_mops`, and its valid bit is `out_slot_vld[0]`.

Top module: `mop_expand_pack`

## Requirements
- R1: Path code 2'b00 gives exactly one macro-op `{2'b00, tag, 2'd0}`. The unused code 2'b11 is treated the same way and gives the same single macro-op with kind 2'b00.
- R2: Path code 2'b01 gives exactly two macro-ops, `{2'b01, tag, 2'd0}` then `{2'b01, tag, 2'd1}`, and they leave in that order.
- R3: Path code 2'b10 gives the table sequence for the tag. Its length is (tag mod 4) + 1, and its macro-ops are `{2'b10, tag, step}` for steps 0 upward. At most three of them enter the queue per cycle, and the first three enter in the cycle the instruction is accepted.
- R4: While a table sequence still has macro-ops left to emit, `in_ready` is low.
- R5: `out_valid` is high without flush only when at least three macro-ops are queued, and every such group has `out_slot_vld` = 3'b111.
- R6: With `flush` high and one or two macro-ops queued, a group is offered at once. The queued macro-ops occupy the low slots and the remaining slots have a valid bit of 0.
- R7: Macro-ops leave in the order their instructions were accepted, and none is lost or duplicated.
- R8: `in_ready` is low whenever the queue holds more than BUF_DEPTH−3 macro-ops. With the default depth of 6 and no draining, exactly four single-rate instructions are taken.
- R9: A synchronous reset empties the queue and abandons any sequence in progress. After reset, `out_valid` is 0 even when `flush` is high, and `in_ready` is 1.
- R10: A full group offered while `out_ready` is low stays offered, with unchanged contents, on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Instruction taken at this edge if valid |
| in_tag | input | 4 | Opcode tag |
| in_path | input | 2 | Path code: 00 single, 01 double, 10 sequenced, 11 treated as single |
| flush | input | 1 | Release a partial group |
| out_valid | output | 1 | Group offered |
| out_ready | input | 1 | Group consumed at this edge if offered |
| out_slot_vld | output | 3 | Per-slot valid bits, bit 0 is slot 0 |
| out_mops | output | 24 | Three 8-bit macro-op slots, slot 0 in the low bits |

## Verification
The difficult case is a group pop and a multi-word push that land on the same edge while both queue pointers wrap around the six-entry ring. A second difficult case is a flush that arrives while a sequence is still feeding the queue, so that a partial group leaves between two chunks of the same sequence. The bench provokes both by sweeping every tag with every path code under three downstream-ready patterns and random input gaps. It then drains each pass with flush held high. Each released slot is compared in order against a queue of expected macro-ops, which the bench builds arithmetically from the tag and path code.

// File: rtl/mop_pkg.sv
package mop_pkg;

    localparam int TAG_W     = 4;
    localparam int MAX_VLEN  = 4;
    localparam int STEP_W    = $clog2(MAX_VLEN);
    localparam int KIND_W    = 2;
    localparam int MOP_W     = KIND_W + TAG_W + STEP_W;
    localparam int GROUP     = 3;
    localparam int CNT_W     = $clog2(GROUP + 1);
    localparam int NUM_TAGS  = 1 << TAG_W;

    typedef enum logic [KIND_W-1:0] {
        PATH_SINGLE = 2'b00,
        PATH_DOUBLE = 2'b01,
        PATH_VECTOR = 2'b10,
        PATH_RSVD   = 2'b11
    } path_e;

    typedef logic [MOP_W-1:0] mop_t;

    // length of the table sequence owned by a tag
    function automatic int vec_len(input int tag);
        return (tag % MAX_VLEN) + 1;
    endfunction

    // first table word of a tag: sequences are stored back to back
    function automatic int vec_start(input int tag);
        int acc;
        acc = 0;
        for (int t = 0; t < tag; t++) begin
            acc += vec_len(t);
        end
        return acc;
    endfunction

    localparam int ROM_DEPTH = vec_start(NUM_TAGS);
    localparam int ROM_AW    = $clog2(ROM_DEPTH + GROUP);

endpackage

// File: rtl/mop_ucode_rom.sv
module mop_ucode_rom
    import mop_pkg::*;
(
    input  logic [TAG_W-1:0]             tag_i,
    output logic [ROM_AW-1:0]            start_o,
    input  logic [GROUP-1:0][ROM_AW-1:0] addr_i,
    output mop_t [GROUP-1:0]             mop_o,
    output logic [GROUP-1:0]             last_o
);

    typedef struct packed {
        logic last;
        mop_t mop;
    } uword_t;

    uword_t            rom_tbl   [ROM_DEPTH];
    logic [ROM_AW-1:0] start_tbl [NUM_TAGS];

    // table contents computed from the tag and step arithmetic
    for (genvar t = 0; t < NUM_TAGS; t++) begin : g_tag
        assign start_tbl[t] = ROM_AW'(vec_start(t));
        for (genvar s = 0; s < MAX_VLEN; s++) begin : g_step
            if (s < vec_len(t)) begin : g_word
                assign rom_tbl[vec_start(t) + s] = '{
                    last: (s == vec_len(t) - 1),
                    mop:  {PATH_VECTOR, TAG_W'(t), STEP_W'(s)}
                };
            end
        end
    end

    assign start_o = start_tbl[tag_i];

    // three independent read ports; words past the end read as zero
    for (genvar p = 0; p < GROUP; p++) begin : g_port
        uword_t rd_word;
        assign rd_word   = (int'(addr_i[p]) < ROM_DEPTH) ? rom_tbl[addr_i[p]] : '0;
        assign mop_o[p]  = rd_word.mop;
        assign last_o[p] = rd_word.last;
    end

endmodule

// File: rtl/mop_simple_dec.sv
module mop_simple_dec
    import mop_pkg::*;
(
    input  logic [TAG_W-1:0] tag_i,
    input  path_e            path_i,
    output logic [CNT_W-1:0] cnt_o,
    output mop_t [GROUP-1:0] mops_o
);

    always_comb begin
        mops_o = '0;
        cnt_o  = '0;
        unique case (path_i)
            PATH_DOUBLE: begin
                cnt_o     = CNT_W'(2);
                mops_o[0] = {PATH_DOUBLE, tag_i, STEP_W'(0)};
                mops_o[1] = {PATH_DOUBLE, tag_i, STEP_W'(1)};
            end
            PATH_VECTOR: begin
                cnt_o = '0;
            end
            default: begin
                cnt_o     = CNT_W'(1);
                mops_o[0] = {PATH_SINGLE, tag_i, STEP_W'(0)};
            end
        endcase
    end

endmodule

// File: rtl/mop_seq.sv
module mop_seq
    import mop_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             advance_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] emit_cnt_o,
    output mop_t [GROUP-1:0] emit_mops_o
);

    typedef struct packed {
        logic              busy;
        logic [ROM_AW-1:0] addr;
    } seq_st_t;

    seq_st_t st_q, st_d;

    logic [GROUP-1:0][ROM_AW-1:0] rd_addr;
    logic [GROUP-1:0]             rd_last;
    logic [ROM_AW-1:0]            start_addr;
    logic [ROM_AW-1:0]            base;
    logic                         run;

    mop_ucode_rom u_rom (
        .tag_i   (tag_i),
        .start_o (start_addr),
        .addr_i  (rd_addr),
        .mop_o   (emit_mops_o),
        .last_o  (rd_last)
    );

    assign base = st_q.busy ? st_q.addr : start_addr;
    assign run  = st_q.busy ? advance_i : start_i;

    always_comb begin
        for (int p = 0; p < GROUP; p++) begin
            rd_addr[p] = base + ROM_AW'(p);
        end
    end

    always_comb begin
        logic             hit;
        logic [CNT_W-1:0] n;
        hit = 1'b0;
        n   = CNT_W'(GROUP);
        // lowest flagged word ends the chunk
        for (int p = GROUP - 1; p >= 0; p--) begin
            if (rd_last[p]) begin
                hit = 1'b1;
                n   = CNT_W'(p + 1);
            end
        end
        st_d       = st_q;
        emit_cnt_o = '0;
        if (run) begin
            emit_cnt_o = n;
            if (hit) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.busy = 1'b1;
                st_d.addr = base + ROM_AW'(GROUP);
            end
        end
    end

    assign busy_o = st_q.busy;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/mop_pack_queue.sv
module mop_pack_queue
    import mop_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [CNT_W-1:0]           push_cnt_i,
    input  mop_t [GROUP-1:0]           push_mops_i,
    input  logic                       flush_i,
    input  logic                       pop_ready_i,
    output logic                       grp_valid_o,
    output logic [GROUP-1:0]           grp_slot_vld_o,
    output mop_t [GROUP-1:0]           grp_mops_o,
    output logic [$clog2(DEPTH+1)-1:0] fill_o
);

    localparam int PTR_W  = $clog2(DEPTH);
    localparam int FILL_W = $clog2(DEPTH + 1);

    typedef struct packed {
        mop_t [DEPTH-1:0]  mem;
        logic [PTR_W-1:0]  head;
        logic [PTR_W-1:0]  tail;
        logic [FILL_W-1:0] fill;
    } q_st_t;

    q_st_t st_q, st_d;

    // ring pointer advance for a depth that need not be a power of two
    function automatic logic [PTR_W-1:0] ptr_add(input logic [PTR_W-1:0] p, input int k);
        int s;
        s = int'(p) + k;
        if (s >= DEPTH) s -= DEPTH;
        return PTR_W'(s);
    endfunction

    always_comb begin
        int fill_n;
        int pop_n;
        int push_n;
        st_d   = st_q;
        fill_n = int'(st_q.fill);
        push_n = int'(push_cnt_i);

        grp_valid_o = (fill_n >= GROUP) || (flush_i && (fill_n != 0));
        for (int i = 0; i < GROUP; i++) begin
            grp_mops_o[i]     = st_q.mem[ptr_add(st_q.head, i)];
            grp_slot_vld_o[i] = (i < fill_n);
        end

        pop_n = 0;
        if (grp_valid_o && pop_ready_i) begin
            pop_n = (fill_n < GROUP) ? fill_n : GROUP;
        end

        for (int i = 0; i < GROUP; i++) begin
            if (i < push_n) begin
                st_d.mem[ptr_add(st_q.tail, i)] = push_mops_i[i];
            end
        end

        st_d.head = ptr_add(st_q.head, pop_n);
        st_d.tail = ptr_add(st_q.tail, push_n);
        st_d.fill = FILL_W'(fill_n - pop_n + push_n);
    end

    assign fill_o = st_q.fill;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/mop_expand_pack.sv
module mop_expand_pack
    import mop_pkg::*;
#(
    parameter int BUF_DEPTH = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [TAG_W-1:0]       in_tag,
    input  logic [1:0]             in_path,
    input  logic                   flush,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [GROUP-1:0]       out_slot_vld,
    output logic [GROUP*MOP_W-1:0] out_mops
);

    localparam int FILL_W = $clog2(BUF_DEPTH + 1);

    path_e             path;
    logic              accept;
    logic              room;
    logic              seq_busy;
    logic              seq_start;
    logic [FILL_W-1:0] fill;

    logic [CNT_W-1:0]  simple_cnt;
    mop_t [GROUP-1:0]  simple_mops;
    logic [CNT_W-1:0]  seq_cnt;
    mop_t [GROUP-1:0]  seq_mops;
    logic [CNT_W-1:0]  push_cnt;
    mop_t [GROUP-1:0]  push_mops;
    mop_t [GROUP-1:0]  grp_mops;

    assign path      = path_e'(in_path);
    // room is judged on the registered fill, so any next chunk fits
    assign room      = int'(fill) <= (BUF_DEPTH - GROUP);
    assign in_ready  = room && !seq_busy;
    assign accept    = in_valid && in_ready;
    assign seq_start = accept && (path == PATH_VECTOR);

    mop_simple_dec u_dec (
        .tag_i  (in_tag),
        .path_i (path),
        .cnt_o  (simple_cnt),
        .mops_o (simple_mops)
    );

    mop_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (seq_start),
        .tag_i       (in_tag),
        .advance_i   (room),
        .busy_o      (seq_busy),
        .emit_cnt_o  (seq_cnt),
        .emit_mops_o (seq_mops)
    );

    always_comb begin
        push_cnt  = '0;
        push_mops = simple_mops;
        if (seq_cnt != '0) begin
            push_cnt  = seq_cnt;
            push_mops = seq_mops;
        end else if (accept) begin
            push_cnt  = simple_cnt;
        end
    end

    mop_pack_queue #(
        .DEPTH (BUF_DEPTH)
    ) u_queue (
        .clk            (clk),
        .rst            (rst),
        .push_cnt_i     (push_cnt),
        .push_mops_i    (push_mops),
        .flush_i        (flush),
        .pop_ready_i    (out_ready),
        .grp_valid_o    (out_valid),
        .grp_slot_vld_o (out_slot_vld),
        .grp_mops_o     (grp_mops),
        .fill_o         (fill)
    );

    assign out_mops = grp_mops;

endmodule

// File: rtl/mop_expand_pack_chk.sv
module mop_expand_pack_chk
    import mop_pkg::*;
#(
    parameter int BUF_DEPTH = 6
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           in_ready,
    input logic                           flush,
    input logic                           out_valid,
    input logic                           out_ready,
    input logic [GROUP-1:0]               out_slot_vld,
    input logic [GROUP*MOP_W-1:0]         out_mops,
    input logic                           seq_busy,
    input logic [$clog2(BUF_DEPTH+1)-1:0] fill
);

    AST_FULL_WITHOUT_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !flush) |-> (out_slot_vld == 3'b111)); // R5

    AST_SLOTS_PACKED_LOW: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_slot_vld == 3'b001 || out_slot_vld == 3'b011 || out_slot_vld == 3'b111)); // R6

    AST_NO_ACCEPT_MIDSEQ: assert property (@(posedge clk) disable iff (rst)
        seq_busy |-> !in_ready); // R4

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        int'(fill) <= BUF_DEPTH); // R8

    AST_READY_NEEDS_ROOM: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (int'(fill) <= BUF_DEPTH - GROUP)); // R8

    AST_HOLD_GROUP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && out_slot_vld == 3'b111) |=> (out_valid && $stable(out_mops))); // R10

endmodule

bind mop_expand_pack mop_expand_pack_chk #(.BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .flush        (flush),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_slot_vld (out_slot_vld),
    .out_mops     (out_mops),
    .seq_busy     (seq_busy),
    .fill         (fill)
);

// File: tb/mop_expand_pack_bench.sv
module mop_expand_pack_bench;
    import mop_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 6;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [TAG_W-1:0]       in_tag = '0;
    logic [1:0]             in_path = '0;
    logic                   flush = 1'b0;
    logic                   out_valid;
    logic                   out_ready = 1'b0;
    logic [GROUP-1:0]       out_slot_vld;
    logic [GROUP*MOP_W-1:0] out_mops;

    int        checks = 0;
    int        errors = 0;
    int        rdy_mode = -1;
    bit        accepted = 0;
    bit        done = 0;
    logic [15:0] lfsr = 16'hACE1;
    mop_t      ref_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mop_expand_pack #(.BUF_DEPTH(DEPTH)) u_mop_expand_pack (
        .clk, .rst, .in_valid, .in_ready, .in_tag, .in_path, .flush,
        .out_valid, .out_ready, .out_slot_vld, .out_mops
    );

    function automatic mop_t mk(input int kind, input int tag, input int step);
        return mop_t'((kind << (TAG_W + STEP_W)) | (tag << STEP_W) | step);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic push_ref(input int tag, input int path);
        case (path)
            1: begin ref_q.push_back(mk(1, tag, 0)); ref_q.push_back(mk(1, tag, 1)); end
            2: for (int s = 0; s < (tag % 4) + 1; s++) ref_q.push_back(mk(2, tag, s));
            default: ref_q.push_back(mk(0, tag, 0));
        endcase
    endtask

    task automatic check_group();
        logic [2:0] sv;
        sv = out_slot_vld;
        if (!flush) chk(sv == 3'b111, "R5", "slot valids without flush", sv, 3'b111);
        else chk(sv == 3'b001 || sv == 3'b011 || sv == 3'b111, "R6", "slot valids on flush", sv, 3'b011);
        for (int i = 0; i < GROUP; i++) begin
            if (sv[i]) begin
                mop_t got;
                got = out_mops[i*MOP_W +: MOP_W];
                if (ref_q.size() == 0) begin
                    chk(1'b0, "R7", "macro-op with nothing expected", got, 0);
                end else begin
                    mop_t exp;
                    int   kind;
                    exp  = ref_q.pop_front();
                    kind = int'(exp) >> (TAG_W + STEP_W);
                    chk(got == exp, kind == 1 ? "R2 R7" : (kind == 2 ? "R3 R7" : "R1 R7"),
                        "slot macro-op", got, exp);
                end
            end
        end
    endtask

    task automatic tick();
        if (rdy_mode == 0)      out_ready = 1'b1;
        else if (rdy_mode == 1) out_ready = lfsr[0];
        else if (rdy_mode == 2) out_ready = lfsr[0] & lfsr[3];
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        #1;
        if (in_valid && in_ready) begin
            accepted = 1;
            push_ref(int'(in_tag), int'(in_path));
        end
        if (out_valid && out_ready) check_group();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send(input int tag, input int path);
        in_tag   = TAG_W'(tag);
        in_path  = 2'(path);
        in_valid = 1'b1;
        accepted = 0;
        for (int k = 0; k < 200 && !accepted; k++) tick();
        in_valid = 1'b0;
    endtask

    task automatic drain(input string tagtxt);
        flush = 1'b1;
        for (int k = 0; k < 600 && ref_q.size() != 0; k++) tick();
        tick();
        #1;
        chk(ref_q.size() == 0, "R7", {tagtxt, " expected macro-ops left"}, ref_q.size(), 0);
        chk(!out_valid, "R7", {tagtxt, " group left after drain"}, out_valid, 0);
        flush = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n_acc;
        mop_t held;
        @(negedge clk);
        // R9: state while and after reset
        tick(); tick();
        #1;
        chk(!out_valid, "R9", "out_valid in reset", out_valid, 0);
        chk(in_ready, "R9", "in_ready in reset", in_ready, 1);
        rst = 1'b0;

        // R5 and R6: a lone macro-op waits until flush
        out_ready = 1'b1;
        send(5, 0);
        tick(); tick(); tick();
        #1;
        chk(!out_valid, "R5", "group offered with one entry", out_valid, 0);
        flush = 1'b1;
        #1;
        chk(out_valid, "R6", "flush offers partial group", out_valid, 1);
        chk(out_slot_vld == 3'b001, "R6", "partial slot valids", out_slot_vld, 3'b001);
        chk(out_mops[MOP_W-1:0] == mk(0, 5, 0), "R1", "slot 0 macro-op", out_mops[MOP_W-1:0], mk(0, 5, 0));
        drain("r6_single");

        // R8: no drain, four singles fit, then ready drops
        out_ready = 1'b0;
        n_acc = 0;
        in_valid = 1'b1;
        in_path = 2'b00;
        for (int k = 0; k < 8; k++) begin
            in_tag = TAG_W'(n_acc);
            accepted = 0;
            tick();
            if (accepted) n_acc++;
        end
        in_valid = 1'b0;
        #1;
        chk(n_acc == 4, "R8", "singles taken with full queue", n_acc, 4);
        chk(!in_ready, "R8", "in_ready with fill 4", in_ready, 0);
        // R10: full group held while not consumed
        held = out_mops[MOP_W-1:0];
        chk(out_valid && out_slot_vld == 3'b111, "R10", "full group offered", out_slot_vld, 3'b111);
        tick();
        #1;
        chk(out_valid && out_mops[MOP_W-1:0] == held, "R10", "held slot 0", out_mops[MOP_W-1:0], held);
        rdy_mode = 0;
        drain("r8_fill");

        // R3 and R4: four-long sequence, first chunk of three at once
        rdy_mode = -1;
        out_ready = 1'b0;
        send(3, 2);
        #1;
        chk(!in_ready, "R4", "in_ready mid sequence", in_ready, 0);
        chk(out_valid && out_slot_vld == 3'b111, "R3", "first chunk size", out_slot_vld, 3'b111);
        chk(out_mops == {mk(2, 3, 2), mk(2, 3, 1), mk(2, 3, 0)}, "R3", "first chunk contents",
            out_mops, {mk(2, 3, 2), mk(2, 3, 1), mk(2, 3, 0)});
        rdy_mode = 0;
        drain("r3_seq");

        // R9: reset in the middle of a stream
        rdy_mode = -1;
        out_ready = 1'b0;
        send(7, 2);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        ref_q.delete();
        flush = 1'b1;
        #1;
        chk(!out_valid, "R9", "out_valid after mid-run reset", out_valid, 0);
        chk(in_ready, "R9", "in_ready after mid-run reset", in_ready, 1);
        flush = 1'b0;

        // sweep every tag with every path code under three ready patterns
        for (int pass = 0; pass < 3; pass++) begin
            rdy_mode = pass;
            for (int t = 0; t < NUM_TAGS; t++) begin
                for (int p = 0; p < 4; p++) begin
                    if (lfsr[5] && lfsr[9]) tick();
                    send(t, (p + t + pass) % 4);
                    if (lfsr[2] && lfsr[7]) begin
                        flush = 1'b1;
                        tick();
                        flush = 1'b0;
                    end
                end
            end
            drain("r7_sweep");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule